// File: doc/BRIEF.md
# Revolution Carry Pulse Generator

This block turns the step activity of a position up/down counter into a revolution marker. Each time the counter takes a step, it raises a step strobe. A direction level tells which way the counter is moving. A one-cycle carry flag says that the step wrapped the count at the selected resolution, either from all ones to all zeros or from all zeros to all ones. The block answers by raising a single marker level. External pitch or revolution counters treat the rising edge of that level as "one more turn done".

The marker has to stay high for a minimum time, set as a number of nanoseconds. It is then dropped, which in normal operation happens before the next step strobe. A motion reversal while the marker is high makes the clear wait. The clear waits until two successive strobe rising edges have sampled the same direction. Between strobes, the direction level may flicker when motion reverses by less than one count; only its value at strobe edges settles the matter. Inhibiting the position output latch has no bearing on the marker, so the block has no such input.

All inputs are plain levels sampled on one clock, and the reset is synchronous. The clock period and the minimum high time are parameters. The block derives the hold length in cycles, rounded up.

Top module: `rev_marker_gen`

## Requirements
- R1: A strobe rising edge (strobe high in this cycle, low in the previous cycle) with the carry flag high drives the marker high in the next cycle. This holds whatever the direction level is.
- R2: The minimum hold is MIN_HIGH_CYC = ceil(MIN_HIGH_PS / CLK_PERIOD_PS) cycles, which is 30 with the defaults. Once raised, the marker stays high for at least this many cycles. With no direction change it falls exactly after that many cycles.
- R3: If the direction level differs from its previous-cycle value while the marker is high, the marker stays high. It stays high until two consecutive strobe rising edges have sampled equal direction values. It then falls one cycle after the second of those edges, provided the hold of R2 has run out.
- R4: Once a direction change is pending, further direction toggles between strobe edges do not restart the wait. Only the direction values present at strobe rising edges count.
- R5: The carry flag has no effect unless it coincides with a strobe rising edge. A carry while the strobe is low, or while the strobe is held high after its edge, leaves the marker unchanged.
- R6: A new carry step while the marker is already high restarts the hold of R2 from that step and cancels any pending direction wait.
- R7: A synchronous reset drives the marker low at the next clock edge and clears any pending direction wait.
- R8: The marker never falls at the clock edge that ends a cycle in which the direction level changed while the marker was high. The exception is a new carry step in that cycle, which keeps the marker high anyway.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_strobe_i | input | 1 | Counter step strobe; its rising edge marks one step |
| step_dir_i | input | 1 | Direction level: 1 counting up, 0 counting down |
| major_carry_i | input | 1 | One-cycle flag: this step wrapped the count |
| rev_marker_o | output | 1 | Revolution marker level; its rising edge marks a full turn |

## Verification
The guard and the hold timer both hide their errors until the marker falls. A guard stuck in a waiting state shows as a marker that never drops after two equal-direction strobes. A guard that settles too soon shows as a marker falling one cycle after a reversal. A hold counter that is off by one moves the falling edge by exactly one cycle. For that reason the checks sample the marker on the last expected high cycle and on the first expected low cycle. A faulty edge sampler shows within one cycle of a strobe: either a missing rise, or a spurious rise from a carry that arrives with the strobe held high.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  // Direction-stability guard states
  typedef enum logic [1:0] {
    GD_SETTLED     = 2'd0,  // no reversal pending
    GD_WAIT_FIRST  = 2'd1,  // reversal seen, no strobe sample yet
    GD_WAIT_SECOND = 2'd2   // one strobe sample held, waiting for a matching one
  } guard_state_e;

  // Integer division rounded up, used to turn a time into a cycle count
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rcp_edge_sampler.sv
// Registers the strobe and direction levels once per cycle.
// Produces the strobe rising edge, a qualified carry step and a direction change flag.
module rcp_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic dir_i,
  input  logic carry_i,
  output logic rise_o,
  output logic carry_step_o,
  output logic dir_changed_o
);

  logic strobe_q;
  logic dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      dir_q    <= dir_i;  // capture the present level so release makes no false change
    end else begin
      strobe_q <= strobe_i;
      dir_q    <= dir_i;
    end
  end

  always_comb begin
    rise_o        = strobe_i & ~strobe_q;
    carry_step_o  = rise_o & carry_i;
    dir_changed_o = dir_i ^ dir_q;
  end

endmodule

// File: rtl/rcp_hold_timer.sv
// Counts down the minimum high time from the cycle the marker is raised.
module rcp_hold_timer #(
  parameter int HOLD_CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic done_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/rcp_dir_guard.sv
// Tracks the direction-stability rule that gates the marker clear.
module rcp_dir_guard (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic marker_i,
  input  logic rise_i,
  input  logic dir_i,
  input  logic dir_changed_i,
  output logic settled_o
);

  import rcp_pkg::*;

  guard_state_e state_q;
  logic         ref_dir_q;
  logic         reversal;

  assign reversal = marker_i & dir_changed_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      state_q   <= GD_SETTLED;
      ref_dir_q <= 1'b0;
    end else begin
      unique case (state_q)
        GD_SETTLED: begin
          if (reversal) begin
            // a strobe edge in the same cycle already counts as the first sample
            state_q   <= rise_i ? GD_WAIT_SECOND : GD_WAIT_FIRST;
            ref_dir_q <= dir_i;
          end
        end
        GD_WAIT_FIRST: begin
          if (rise_i) begin
            state_q   <= GD_WAIT_SECOND;
            ref_dir_q <= dir_i;
          end
        end
        GD_WAIT_SECOND: begin
          if (rise_i) begin
            if (dir_i == ref_dir_q) begin
              state_q <= GD_SETTLED;
            end else begin
              ref_dir_q <= dir_i;
            end
          end
        end
        default: state_q <= GD_SETTLED;
      endcase
    end
  end

  // a reversal in the present cycle blocks the clear at once
  assign settled_o = (state_q == GD_SETTLED) & ~reversal;

endmodule

// File: rtl/rev_marker_gen.sv
module rev_marker_gen #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_HIGH_PS   = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_strobe_i,
  input  logic step_dir_i,
  input  logic major_carry_i,
  output logic rev_marker_o
);

  localparam int MIN_HIGH_RAW = rcp_pkg::ceil_div(MIN_HIGH_PS, CLK_PERIOD_PS);
  localparam int MIN_HIGH_CYC = (MIN_HIGH_RAW < 1) ? 1 : MIN_HIGH_RAW;

  logic strobe_rise;
  logic carry_step;
  logic dir_changed;
  logic hold_done;
  logic guard_ok;
  logic marker_q;

  rcp_edge_sampler u_sampler (
    .clk           (clk),
    .rst           (rst),
    .strobe_i      (step_strobe_i),
    .dir_i         (step_dir_i),
    .carry_i       (major_carry_i),
    .rise_o        (strobe_rise),
    .carry_step_o  (carry_step),
    .dir_changed_o (dir_changed)
  );

  rcp_hold_timer #(
    .HOLD_CYC (MIN_HIGH_CYC)
  ) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (carry_step),
    .done_o (hold_done)
  );

  rcp_dir_guard u_guard (
    .clk           (clk),
    .rst           (rst),
    .restart_i     (carry_step),
    .marker_i      (marker_q),
    .rise_i        (strobe_rise),
    .dir_i         (step_dir_i),
    .dir_changed_i (dir_changed),
    .settled_o     (guard_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      marker_q <= 1'b0;
    end else if (carry_step) begin
      marker_q <= 1'b1;
    end else if (marker_q && hold_done && guard_ok) begin
      marker_q <= 1'b0;
    end
  end

  assign rev_marker_o = marker_q;

endmodule

// File: rtl/rev_marker_gen_chk.sv
module rev_marker_gen_chk #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_HIGH_PS   = 300000
) (
  input logic clk,
  input logic rst,
  input logic strobe,
  input logic dir,
  input logic carry,
  input logic marker,
  input logic settled_ok
);

  localparam int MIN_RAW = rcp_pkg::ceil_div(MIN_HIGH_PS, CLK_PERIOD_PS);
  localparam int MIN_CYC = (MIN_RAW < 1) ? 1 : MIN_RAW;

  logic strobe_q;
  logic dir_q;
  logic marker_q;
  logic rst_q;
  int unsigned hi_len;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      strobe_q <= 1'b0;
      dir_q    <= dir;
      marker_q <= 1'b0;
      hi_len   <= 0;
    end else begin
      strobe_q <= strobe;
      dir_q    <= dir;
      marker_q <= marker;
      if (marker) hi_len <= (hi_len < MIN_CYC) ? hi_len + 1 : hi_len;
      else        hi_len <= 0;
    end
  end

  // R1: a carry step raises the marker in the next cycle
  a_r1_carry_raises: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q && carry) |=> marker);

  // R2: the marker never falls before the minimum hold has elapsed
  a_r2_min_width: assert property (@(posedge clk) disable iff (rst)
    (marker_q && !marker) |-> (hi_len >= MIN_CYC));

  // R3: a fall happens only when the direction guard reported settled
  a_r3_guarded_fall: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $fell(marker)) |-> $past(settled_ok));

  // R7: reset forces the marker low
  a_r7_reset_low: assert property (@(posedge clk)
    rst |=> !marker);

  // R8: a reversal while high keeps the marker up at the following edge
  a_r8_hold_on_reversal: assert property (@(posedge clk) disable iff (rst)
    (marker && (dir != dir_q)) |=> marker);

endmodule

bind rev_marker_gen rev_marker_gen_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .MIN_HIGH_PS   (MIN_HIGH_PS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe     (step_strobe_i),
  .dir        (step_dir_i),
  .carry      (major_carry_i),
  .marker     (rev_marker_o),
  .settled_ok (guard_ok)
);

// File: tb/test_rev_marker_gen.sv
module test_rev_marker_gen;

  localparam int CLK_PERIOD = 10;  // ns, matches the default CLK_PERIOD_PS

  typedef struct packed {
    logic       dir;
    logic       carry;
    logic [7:0] wait_n;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // One step per entry: set dir, pulse the strobe with carry, wait, then sample the marker.
  localparam vec_t TABLE [11] = '{
    '{1'b1, 1'b1, 8'd29, 1'b1, 4'd2},  // R1 up wrap; R2 last high cycle
    '{1'b1, 1'b0, 8'd0,  1'b0, 4'd2},  // R2 cleared after hold
    '{1'b0, 1'b1, 8'd0,  1'b1, 4'd1},  // R1 down wrap
    '{1'b0, 1'b0, 8'd30, 1'b0, 4'd2},  // R2 clear
    '{1'b0, 1'b1, 8'd5,  1'b1, 4'd1},  // R1
    '{1'b1, 1'b0, 8'd40, 1'b1, 4'd3},  // R3 reversal holds past hold time
    '{1'b1, 1'b0, 8'd1,  1'b0, 4'd3},  // R3 second equal sample clears
    '{1'b1, 1'b1, 8'd3,  1'b1, 4'd1},  // R1
    '{1'b0, 1'b0, 8'd40, 1'b1, 4'd3},  // R3 reversal
    '{1'b1, 1'b0, 8'd40, 1'b1, 4'd3},  // R3 unequal samples keep waiting
    '{1'b1, 1'b0, 8'd1,  1'b0, 4'd3}   // R3 equal samples clear
  };

  logic clk = 1'b0;
  logic rst;
  logic strobe;
  logic dir;
  logic carry;
  logic marker;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rev_marker_gen i_rev_marker_gen (
    .clk           (clk),
    .rst           (rst),
    .step_strobe_i (strobe),
    .step_dir_i    (dir),
    .major_carry_i (carry),
    .rev_marker_o  (marker)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s marker actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic c);
    @(negedge clk) dir = d;
    @(negedge clk) begin strobe = 1'b1; carry = c; end
    @(negedge clk) begin strobe = 1'b0; carry = 1'b0; end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; strobe = 1'b0; dir = 1'b0; carry = 1'b0;
    wait_n(3);
    check(marker, 1'b0, "R7 reset state");
    dir = 1'b1;
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < 11; i++) begin
      step(TABLE[i].dir, TABLE[i].carry);
      wait_n(int'(TABLE[i].wait_n));
      check(marker, TABLE[i].exp, $sformatf("R%0d vector %0d", TABLE[i].req, i));
    end

    // R6: a second carry step restarts the hold
    step(1'b1, 1'b1);
    wait_n(20);
    check(marker, 1'b1, "R6 first carry");
    step(1'b1, 1'b1);
    wait_n(29);
    check(marker, 1'b1, "R6 restarted hold still high");
    wait_n(1);
    check(marker, 1'b0, "R6 clears after restarted hold");

    // R4: toggles between strobes do not restart the wait
    step(1'b1, 1'b1);
    @(negedge clk) dir = 1'b0;
    @(negedge clk) dir = 1'b1;
    @(negedge clk) dir = 1'b0;
    @(negedge clk) dir = 1'b1;
    wait_n(40);
    check(marker, 1'b1, "R4 pending after toggles");
    step(1'b1, 1'b0);
    wait_n(1);
    check(marker, 1'b1, "R4 one strobe sample only");
    step(1'b1, 1'b0);
    wait_n(1);
    check(marker, 1'b0, "R4 two equal samples clear");

    // R7: reset mid-marker with a reversal pending
    step(1'b1, 1'b1);
    @(negedge clk) dir = 1'b0;
    @(negedge clk) dir = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(marker, 1'b0, "R7 reset drops marker");
    @(negedge clk) rst = 1'b0;
    step(1'b1, 1'b1);
    wait_n(29);
    check(marker, 1'b1, "R7 R2 hold after reset");
    wait_n(1);
    check(marker, 1'b0, "R7 pending wait cleared by reset");

    // R5: carry with strobe low
    @(negedge clk) carry = 1'b1;
    @(negedge clk) carry = 1'b0;
    wait_n(2);
    check(marker, 1'b0, "R5 carry without strobe");

    // R5: carry while the strobe is held high after its edge
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) carry = 1'b1;
    @(negedge clk) begin carry = 1'b0; strobe = 1'b0; end
    wait_n(2);
    check(marker, 1'b0, "R5 carry during held strobe");

    // R1: the same strobe edge with carry still raises the marker at once
    step(1'b0, 1'b1);
    check(marker, 1'b1, "R1 immediate rise");

    finish_run();
  end

endmodule